// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block maps a flat, contiguous virtual address space onto a physical space. The physical regions behind that space move from one operating phase to the next. Four windows are laid end to end in virtual space. Each window has a programmable physical start. The first three windows also have a programmable size. The last window has a fixed span set by a parameter, and it has no size register.

A window's virtual base is the sum of the sizes of every window before it. An access that lands in a window leaves with that window's physical start plus its offset into the window. The windows may point at unrelated physical areas, so the physical result is not contiguous even though virtual space is.

A simple write port loads the window registers. Requests come with a valid strobe. The translated address, or a miss flag, returns one clock later. Window 1 is the register window, and windows 0, 2 and 3 map memory. The lookup treats all four the same way.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset all window registers are zero, the response outputs are low and zero, and every request misses.
- R2: Window 0 covers virtual addresses 0 up to size0 minus 1, and the result is start0 plus the address.
- R3: Window 1 begins at virtual size0 and covers size1 bytes. The result is start1 plus (address minus size0).
- R4: Window 2 begins at virtual size0 plus size1 and covers size2 bytes, translated from start2 in the same way.
- R5: Window 3 begins at virtual size0+size1+size2 and covers TAIL_SPAN bytes from start3. It stays inactive until start3 has been written at least once since reset.
- R6: A request that no active window covers returns rspMiss high with rspAddr zero.
- R7: When windows overlap because the 32-bit base sums wrap, the lowest-numbered matching window is used.
- R8: rspValid is high exactly in the cycle after a cycle with reqValid high. When rspValid is low, rspAddr and rspMiss are zero.
- R9: A request made in the same cycle as a register write is translated with the values from before the write. The next request uses the new values.
- R10: Register select codes are start0=0, size0=1, start1=2, size1=3, start2=4, size2=5, start3=6. A write with select 7 changes nothing.
- R11: A window whose size is zero matches no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select (codes in R10) |
| cfgData | input | ADDR_W | Register write value |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | ADDR_W | Virtual address of the request |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspAddr | output | ADDR_W | Physical address, or zero on a miss |
| rspMiss | output | 1 | No active window covers the request |

## Verification
Every result appears one clock after its stimulus. A request captured at one edge shows on rspValid, rspAddr and rspMiss after the next edge. A register write shapes only requests that come after the cycle in which the write is issued. The bench drives inputs on the falling edge. At that moment it computes the response due from its model, using the register state from before this cycle's write, and only then applies the write to the model. It compares that expected response at the next falling edge, so every cycle is checked, idle cycles included.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int NUM_WIN = 4;
  localparam int NUM_SIZED = NUM_WIN - 1;
  localparam int SEL_W = $clog2(2 * NUM_WIN);

  typedef struct packed {
    logic [NUM_WIN-1:0]   ldStart;
    logic [NUM_SIZED-1:0] ldSize;
    logic                 capture;
    logic                 tailLive;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             reqValid,
  output xlatStrobe_t      strobe
);
  logic [NUM_WIN-1:0]   ldStart;
  logic [NUM_SIZED-1:0] ldSize;
  logic                 tailLiveQ;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_start
    assign ldStart[i] = cfgWe && (int'(cfgSel) == 2 * i);
  end

  for (genvar i = 0; i < NUM_SIZED; i++) begin : g_size
    assign ldSize[i] = cfgWe && (int'(cfgSel) == 2 * i + 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tailLiveQ <= 1'b0;
    else if (ldStart[NUM_WIN-1]) tailLiveQ <= 1'b1;
  end

  always_comb begin
    strobe.ldStart  = ldStart;
    strobe.ldSize   = ldSize;
    strobe.capture  = reqValid;
    strobe.tailLive = tailLiveQ;
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ldStart, ldSize})); // R10

  AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && int'(cfgSel) >= 2 * NUM_WIN - 1) |-> ({ldStart, ldSize} == '0)); // R10

  AST_TAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    tailLiveQ |=> tailLiveQ); // R5

  AST_TAIL_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    ldStart[NUM_WIN-1] |=> tailLiveQ); // R5
endmodule

// File: rtl/xlat_win.sv
module xlat_win #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vAddr,
  input  logic [ADDR_W-1:0] vBase,
  input  logic [ADDR_W-1:0] span,
  input  logic [ADDR_W-1:0] pStart,
  input  logic              live,
  output logic              hit,
  output logic [ADDR_W-1:0] pAddr
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = vAddr - vBase;
    hit    = live && (offset < span);
    pAddr  = pStart + offset;
  end
endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] TAIL_SPAN = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspMiss
);
  logic [ADDR_W-1:0] startQ [NUM_WIN];
  logic [ADDR_W-1:0] sizeQ  [NUM_SIZED];
  logic [ADDR_W-1:0] baseV  [NUM_WIN];
  logic [ADDR_W-1:0] spanV  [NUM_WIN];
  logic [ADDR_W-1:0] pAddrV [NUM_WIN];
  logic [NUM_WIN-1:0] liveV;
  logic [NUM_WIN-1:0] hitV;
  logic [NUM_WIN-1:0] pickV;
  logic               found;
  logic [ADDR_W-1:0]  selAddr;
  logic               rspValidQ;
  logic               rspMissQ;
  logic [ADDR_W-1:0]  rspAddrQ;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_startReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) startQ[i] <= '0;
      else if (strobe.ldStart[i]) startQ[i] <= cfgData;
    end
  end

  for (genvar i = 0; i < NUM_SIZED; i++) begin : g_sizeReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sizeQ[i] <= '0;
      else if (strobe.ldSize[i]) sizeQ[i] <= cfgData;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    if (i == 0) begin : g_first
      assign baseV[i] = '0;
    end else begin : g_next
      assign baseV[i] = baseV[i-1] + sizeQ[i-1];
    end

    if (i < NUM_SIZED) begin : g_sized
      assign spanV[i] = sizeQ[i];
      assign liveV[i] = 1'b1;
    end else begin : g_tail
      assign spanV[i] = TAIL_SPAN;
      assign liveV[i] = strobe.tailLive;
    end

    xlat_win #(.ADDR_W(ADDR_W)) u_win (
      .vAddr (reqAddr),
      .vBase (baseV[i]),
      .span  (spanV[i]),
      .pStart(startQ[i]),
      .live  (liveV[i]),
      .hit   (hitV[i]),
      .pAddr (pAddrV[i])
    );

    AST_ZERO_SIZE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
      (spanV[i] == '0) |-> !hitV[i]); // R11
  end

  always_comb begin
    pickV = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hitV[i] && !found) begin
        pickV[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    selAddr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (pickV[i]) selAddr = selAddr | pAddrV[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      rspMissQ  <= 1'b0;
      rspAddrQ  <= '0;
    end else if (strobe.capture) begin
      rspValidQ <= 1'b1;
      rspMissQ  <= !found;
      rspAddrQ  <= found ? selAddr : '0;
    end else begin
      rspValidQ <= 1'b0;
      rspMissQ  <= 1'b0;
      rspAddrQ  <= '0;
    end
  end

  assign rspValid = rspValidQ;
  assign rspMiss  = rspMissQ;
  assign rspAddr  = rspAddrQ;

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pickV)); // R7

  AST_PICK_FROM_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (pickV & ~hitV) == '0); // R7

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    hitV[0] |-> pickV[0]); // R7

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValidQ); // R8

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !rspValidQ); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValidQ |-> (!rspMissQ && rspAddrQ == '0)); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValidQ && rspMissQ) |-> (rspAddrQ == '0)); // R6

  AST_NOTHING_LIVE_MISSES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && hitV == '0) |=> rspMissQ); // R6
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
  import xlat_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] TAIL_SPAN = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspMiss
);
  xlatStrobe_t strobe;

  xlat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .reqValid(reqValid),
    .strobe  (strobe)
  );

  xlat_dp #(.ADDR_W(ADDR_W), .TAIL_SPAN(TAIL_SPAN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .reqAddr (reqAddr),
    .rspValid(rspValid),
    .rspAddr (rspAddr),
    .rspMiss (rspMiss)
  );
endmodule

// File: tb/tb_addr_window_xlat.sv
module tb_addr_window_xlat;
  localparam logic [31:0] SPAN = 32'h1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic [31:0] rspAddr;
  logic        rspMiss;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // model state
  logic [31:0] mStart [4];
  logic [31:0] mSize  [3];
  bit          mArmed;

  // pending expectation
  bit          expV;
  bit          expM;
  logic [31:0] expA;
  string       expTag;

  always #4 clk = ~clk;

  addr_window_xlat #(.ADDR_W(32), .TAIL_SPAN(SPAN)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspMiss(rspMiss)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic lookup(input logic [31:0] a, output bit miss, output logic [31:0] p);
    logic [31:0] base = 32'h0;
    logic [31:0] span;
    miss = 1'b1;
    p = 32'h0;
    for (int w = 0; w < 4; w++) begin
      span = (w < 3) ? mSize[w] : (mArmed ? SPAN : 32'h0);
      if (miss && (a - base) < span) begin
        miss = 1'b0;
        p = mStart[w] + (a - base);
      end
      if (w < 3) base = base + mSize[w];
    end
  endtask

  task automatic compare();
    checks++;
    if (rspValid !== expV || rspMiss !== expM || rspAddr !== expA) begin
      errors++;
      $display("FAIL %s: actual valid=%0b miss=%0b addr=%h expected valid=%0b miss=%0b addr=%h",
               expTag, rspValid, rspMiss, rspAddr, expV, expM, expA);
    end
  endtask

  task automatic step(input bit we, input logic [2:0] sel, input logic [31:0] data,
                      input bit rv, input logic [31:0] addr, input string tag);
    bit m;
    logic [31:0] p;
    @(negedge clk);
    compare();
    cfgWe = we; cfgSel = sel; cfgData = data;
    reqValid = rv; reqAddr = addr;
    expTag = tag;
    if (rv) begin
      lookup(addr, m, p);
      expV = 1'b1; expM = m; expA = p;
    end else begin
      expV = 1'b0; expM = 1'b0; expA = 32'h0;
    end
    if (we) begin
      case (sel)
        3'd0: mStart[0] = data;
        3'd1: mSize[0]  = data;
        3'd2: mStart[1] = data;
        3'd3: mSize[1]  = data;
        3'd4: mStart[2] = data;
        3'd5: mSize[2]  = data;
        3'd6: begin mStart[3] = data; mArmed = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data, input string tag);
    step(1'b1, sel, data, 1'b0, 32'h0, tag);
  endtask

  task automatic rq(input logic [31:0] addr, input string tag);
    step(1'b0, 3'd0, 32'h0, 1'b1, addr, tag);
  endtask

  task automatic direct(input logic [31:0] addr, input bit miss, input logic [31:0] phys,
                        input string tag);
    // fixed expectation from the requirement text, checked one cycle later
    rq(addr, tag);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b1 || rspMiss !== miss || rspAddr !== phys) begin
      errors++;
      $display("FAIL %s fixed: actual miss=%0b addr=%h expected miss=%0b addr=%h",
               tag, rspMiss, rspAddr, miss, phys);
    end
    compare();
    reqValid = 1'b0;
    expV = 1'b0; expM = 1'b0; expA = 32'h0; expTag = "R8 idle";
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mStart[i] = 32'h0;
    for (int i = 0; i < 3; i++) mSize[i] = 32'h0;
    mArmed = 1'b0;
    expV = 1'b0; expM = 1'b0; expA = 32'h0; expTag = "R1 reset";
    repeat (3) @(negedge clk);
    compare();
    rstN = 1'b1;

    // R1: everything misses after reset
    direct(32'h0, 1'b1, 32'h0, "R1");
    direct(32'h0000_0123, 1'b1, 32'h0, "R1");

    wr(3'd0, 32'h1000_0000, "R10 load start0");
    wr(3'd1, 32'h0000_4000, "R10 load size0");
    wr(3'd2, 32'h3000_0000, "R10 load start1");
    wr(3'd3, 32'h0000_1000, "R10 load size1");
    wr(3'd4, 32'h2000_0000, "R10 load start2");
    wr(3'd5, 32'h0000_8000, "R10 load size2");

    direct(32'h0000_0010, 1'b0, 32'h1000_0010, "R2");
    direct(32'h0000_3FFF, 1'b0, 32'h1000_3FFF, "R2");
    direct(32'h0000_4000, 1'b0, 32'h3000_0000, "R3");
    direct(32'h0000_4FFF, 1'b0, 32'h3000_0FFF, "R3");
    direct(32'h0000_5000, 1'b0, 32'h2000_0000, "R4");
    direct(32'h0000_CFFF, 1'b0, 32'h2000_7FFF, "R4");
    direct(32'h0000_D000, 1'b1, 32'h0, "R5 tail not yet live");

    wr(3'd6, 32'h5000_0000, "R5 load start3");
    direct(32'h0000_D000, 1'b0, 32'h5000_0000, "R5");
    direct(32'h0000_DFFF, 1'b0, 32'h5000_0FFF, "R5");
    direct(32'h0000_E000, 1'b1, 32'h0, "R6");
    direct(32'hFFFF_FFF0, 1'b1, 32'h0, "R6");

    // R9: write and request in the same cycle
    step(1'b1, 3'd1, 32'h0000_8000, 1'b1, 32'h0000_5000, "R9 old values");
    direct(32'h0000_5000, 1'b0, 32'h1000_5000, "R9 new values");
    direct(32'h0000_8000, 1'b0, 32'h3000_0000, "R9 shifted base");

    // R10: select 7 changes nothing
    wr(3'd7, 32'hDEAD_BEEF, "R10 select 7");
    direct(32'h0000_0000, 1'b0, 32'h1000_0000, "R10");
    direct(32'h0000_9000, 1'b0, 32'h2000_0000, "R10");
    direct(32'h0000_11000, 1'b0, 32'h5000_0000, "R10");

    // R11: zero size window 1
    wr(3'd3, 32'h0, "R11 size1 zero");
    direct(32'h0000_8000, 1'b0, 32'h2000_0000, "R11");
    direct(32'h0000_10000, 1'b0, 32'h5000_0000, "R11");

    // R7: wrapped bases overlap, window 0 wins
    wr(3'd1, 32'hFFFF_0000, "R7 size0");
    wr(3'd3, 32'h0002_0000, "R7 size1");
    direct(32'h0000_0100, 1'b0, 32'h1000_0100, "R7");
    direct(32'hFFFF_0010, 1'b0, 32'h3000_0010, "R7");

    // R8: back-to-back and idle patterns against the model
    wr(3'd1, 32'h0000_2000, "R8 size0");
    wr(3'd3, 32'h0000_0800, "R8 size1");
    for (int k = 0; k < 60; k++) begin
      if (k % 3 == 2) step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, "R8 idle");
      else rq($urandom_range(0, 32'h0000_C000), "R8 stream");
    end
    for (int k = 0; k < 40; k++) begin
      step(k % 5 == 0, 3'($urandom_range(0, 7)), $urandom_range(0, 32'h4000),
           1'b1, $urandom_range(0, 32'h0001_4000), "R9 mixed");
    end
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, "R8 idle");
    step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, "R8 idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule